// File: doc/BRIEF.md
# Instruction Fetch Sequencer for an AHB Master

This block sits between a processor's instruction-fetch port and an AHB bus. The fetch port has no early hint that the following fetch will be sequential. It offers a request, an address and a "sequential" flag that arrives in the same cycle as the address. The sequencer turns these requests into AHB read transfers. Every fetch beat on the bus is followed by a BUSY cycle. During that BUSY cycle the core's next address reaches the sequencer and the late flag is sampled. The flag then decides whether the next beat continues the burst as SEQ or restarts it as NONSEQ.

A run of straight-line code gives the pattern NONSEQ, BUSY, SEQ, BUSY, SEQ. A branch breaks this pattern with a NONSEQ at the new target. Fetches that the core flags as served by local tightly-coupled memory cause no bus activity. A sequential continuation that would cross a 1 KB address region is restarted as a NONSEQ, because AHB bursts may not cross that boundary. Read data is handed back to the core in the data phase that completes with HREADY high, and the core is stalled while HREADY is low.

Top module: `fetch_seq_top`

## Requirements
- R1: After reset, htrans is IDLE (2'b00), haddr is 0, and both if_rvalid and if_stall are low.
- R2: While the bus shows IDLE and hready is high, an external fetch request (if_req high, if_local low) puts NONSEQ (2'b10) on htrans at if_addr in the next cycle, whatever the value of if_seq.
- R3: A NONSEQ or SEQ beat accepted with hready high is followed in the next cycle by BUSY (2'b01). In that cycle haddr is the accepted address plus 4.
- R4: From BUSY with hready high, an external request with if_seq high gives SEQ (2'b11) in the next cycle with haddr unchanged, provided that address lies in the same 1 KB region as the previous beat.
- R5: From BUSY with hready high, an external request with if_seq low (a branch) gives NONSEQ at if_addr in the next cycle.
- R6: From IDLE or BUSY with hready high, no request or a request with if_local high gives IDLE in the next cycle. No transfer is issued.
- R7: While hready is low, htrans and haddr hold their values into the next cycle.
- R8: if_rvalid is high, and if_rdata equals hrdata, exactly in a cycle where hready is high and a beat accepted earlier is still in its data phase.
- R9: if_stall is high exactly when a data phase is outstanding and hready is low.
- R10: hburst always reads INCR (3'b001).
- R11: If the incremented address shown during BUSY starts a new 1 KB region, a request with if_seq high gives NONSEQ at that address instead of SEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the core and the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_req | input | 1 | Core requests an instruction fetch |
| if_addr | input | AW | Fetch address |
| if_seq | input | 1 | Late flag: this fetch follows the previous one |
| if_local | input | 1 | Fetch is served by local memory and needs no bus transfer |
| if_rdata | output | DW | Instruction word returned to the core |
| if_rvalid | output | 1 | if_rdata is valid this cycle |
| if_stall | output | 1 | Core must wait for the bus |
| haddr | output | AW | AHB address |
| htrans | output | 2 | AHB transfer type |
| hburst | output | 3 | AHB burst type (always INCR) |
| hready | input | 1 | AHB transfer done / bus ready |
| hrdata | input | DW | AHB read data |

## Verification
The bench targets a beat whose increment lands exactly on a 1 KB edge. A design that ignored the region would issue SEQ there, where NONSEQ is required. Long runs of hready low are applied during BUSY and during data phases. A design that let BUSY advance while the bus waited would show a changed htrans or haddr. The same stimulus also catches if_rvalid raised without hready. Branches and local-memory fetches are placed directly after BUSY. A design that trusted a stale sequential state would issue SEQ on a branch, or issue a transfer for a local fetch.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    localparam logic [2:0] BURST_INCR = 3'b001;

endpackage

// File: rtl/fetch_addr_step.sv
module fetch_addr_step #(
    parameter int AW          = 32,
    parameter int BEAT_BYTES  = 4,
    parameter int REGION_BITS = 10
) (
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] next_addr,
    output logic          new_region
);

    localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

    assign next_addr = cur_addr + STEP;

    generate
        if (REGION_BITS >= AW) begin : g_no_region
            assign new_region = 1'b0;
        end else begin : g_region
            assign new_region = (next_addr[AW-1:REGION_BITS] != cur_addr[AW-1:REGION_BITS]);
        end
    endgenerate

endmodule

// File: rtl/fetch_addr_phase.sv
module fetch_addr_phase
    import fetch_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          if_req,
    input  logic [AW-1:0] if_addr,
    input  logic          if_seq,
    input  logic          if_local,
    input  logic [AW-1:0] step_addr,
    input  logic          step_new_region,
    output htrans_e       htrans,
    output logic [AW-1:0] haddr
);

    typedef struct packed {
        htrans_e       trans;
        logic [AW-1:0] addr;
        logic          brk;
    } aphase_t;

    aphase_t st_d, st_q;
    logic    fetch_ext;

    assign fetch_ext = if_req && !if_local;

    always_comb begin
        st_d = st_q;
        if (hready) begin
            case (st_q.trans)
                TR_NONSEQ, TR_SEQ: begin
                    st_d.trans = TR_BUSY;
                    st_d.addr  = step_addr;
                    st_d.brk   = step_new_region;
                end
                TR_BUSY: begin
                    st_d.brk = 1'b0;
                    if (!fetch_ext) begin
                        st_d.trans = TR_IDLE;
                    end else if (if_seq) begin
                        st_d.trans = st_q.brk ? TR_NONSEQ : TR_SEQ;
                    end else begin
                        st_d.trans = TR_NONSEQ;
                        st_d.addr  = if_addr;
                    end
                end
                default: begin
                    st_d.brk = 1'b0;
                    if (fetch_ext) begin
                        st_d.trans = TR_NONSEQ;
                        st_d.addr  = if_addr;
                    end else begin
                        st_d.trans = TR_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{trans: TR_IDLE, addr: '0, brk: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign htrans = st_q.trans;
    assign haddr  = st_q.addr;

    // R3
    busy_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans[1] && hready) |=> (htrans == TR_BUSY));

    // R7
    hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(htrans) && $stable(haddr)));

    // R6
    no_xfer_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!htrans[1] && hready && (!if_req || if_local)) |=> (htrans == TR_IDLE));

    // R4
    seq_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_BUSY && hready && if_req && !if_local && if_seq) |=>
            (htrans[1] && $stable(haddr)));

    // R5
    branch_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_BUSY && hready && if_req && !if_local && !if_seq) |=>
            (htrans == TR_NONSEQ));

endmodule

// File: rtl/fetch_data_phase.sv
module fetch_data_phase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          beat_valid,
    input  logic [DW-1:0] hrdata,
    output logic [DW-1:0] if_rdata,
    output logic          if_rvalid,
    output logic          if_stall
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (hready) begin
            pend_d = beat_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign if_rvalid = pend_q && hready;
    assign if_stall  = pend_q && !hready;
    assign if_rdata  = hrdata;

    // R8
    data_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && hready) |=> (if_rvalid || if_stall));

    // R9
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(if_stall && if_rvalid));

endmodule

// File: rtl/fetch_seq_top.sv
module fetch_seq_top
    import fetch_seq_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int REGION_BITS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_req,
    input  logic [AW-1:0] if_addr,
    input  logic          if_seq,
    input  logic          if_local,
    output logic [DW-1:0] if_rdata,
    output logic          if_rvalid,
    output logic          if_stall,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic [2:0]    hburst,
    input  logic          hready,
    input  logic [DW-1:0] hrdata
);

    localparam int BEAT_BYTES = DW / 8;

    htrans_e       trans_w;
    logic [AW-1:0] addr_w;
    logic [AW-1:0] step_addr;
    logic          step_new_region;

    fetch_addr_step #(
        .AW         (AW),
        .BEAT_BYTES (BEAT_BYTES),
        .REGION_BITS(REGION_BITS)
    ) u_step (
        .cur_addr  (addr_w),
        .next_addr (step_addr),
        .new_region(step_new_region)
    );

    fetch_addr_phase #(
        .AW(AW)
    ) u_aphase (
        .clk            (clk),
        .rst_n          (rst_n),
        .hready         (hready),
        .if_req         (if_req),
        .if_addr        (if_addr),
        .if_seq         (if_seq),
        .if_local       (if_local),
        .step_addr      (step_addr),
        .step_new_region(step_new_region),
        .htrans         (trans_w),
        .haddr          (addr_w)
    );

    fetch_data_phase #(
        .DW(DW)
    ) u_dphase (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .beat_valid(trans_w[1]),
        .hrdata    (hrdata),
        .if_rdata  (if_rdata),
        .if_rvalid (if_rvalid),
        .if_stall  (if_stall)
    );

    assign htrans = trans_w;
    assign haddr  = addr_w;
    assign hburst = BURST_INCR;

    // R11
    region_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> (haddr[REGION_BITS-1:0] != '0));

endmodule

// File: tb/sim_fetch_seq_top.sv
`timescale 1ns/100ps
module sim_fetch_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_req = 1'b0;
    logic [31:0] if_addr = '0;
    logic        if_seq = 1'b0;
    logic        if_local = 1'b0;
    logic [31:0] if_rdata;
    logic        if_rvalid;
    logic        if_stall;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hburst;
    logic        hready = 1'b1;
    logic [31:0] hrdata = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int unsigned m_tr = 0, m_addr = 0, m_brk = 0, m_pend = 0;
    int unsigned n_tr, n_addr, n_brk, n_pend;
    string m_why = "R1";

    always #2 clk = ~clk;

    fetch_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .if_req(if_req), .if_addr(if_addr), .if_seq(if_seq),
        .if_local(if_local), .if_rdata(if_rdata), .if_rvalid(if_rvalid), .if_stall(if_stall),
        .haddr(haddr), .htrans(htrans), .hburst(hburst), .hready(hready), .hrdata(hrdata)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit rq, input int unsigned a, input bit sq, input bit lc, input bit rdy);
        @(negedge clk);
        if_req = rq; if_addr = a; if_seq = sq; if_local = lc; hready = rdy;
        hrdata = $urandom;
        #1;
        chk(m_why, "htrans", htrans, m_tr);
        chk(m_why, "haddr", haddr, m_addr);
        chk("R10", "hburst", hburst, 3'b001);
        chk("R8", "if_rvalid", if_rvalid, (m_pend != 0) && rdy);
        if (m_pend != 0 && rdy) chk("R8", "if_rdata", if_rdata, hrdata);
        chk("R9", "if_stall", if_stall, (m_pend != 0) && !rdy);
        // next-state of the reference
        n_tr = m_tr; n_addr = m_addr; n_brk = m_brk; n_pend = m_pend;
        if (!rdy) begin
            m_why = "R7";
        end else begin
            n_pend = (m_tr >= 2) ? 1 : 0;
            n_brk = 0;
            if (m_tr >= 2) begin
                n_tr = 1; n_addr = m_addr + 4;
                n_brk = ((m_addr + 4) / 1024 != m_addr / 1024) ? 1 : 0;
                m_why = "R3";
            end else if (!rq || lc) begin
                n_tr = 0; m_why = "R6";
            end else if (m_tr == 0) begin
                n_tr = 2; n_addr = a; m_why = "R2";
            end else if (!sq) begin
                n_tr = 2; n_addr = a; m_why = "R5";
            end else if (m_brk != 0) begin
                n_tr = 2; m_why = "R11";
            end else begin
                n_tr = 3; m_why = "R4";
            end
        end
        @(posedge clk);
        #0.1;
        m_tr = n_tr; m_addr = n_addr; m_brk = n_brk; m_pend = n_pend;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "htrans", htrans, 0);
        chk("R1", "haddr", haddr, 0);
        chk("R1", "if_rvalid", if_rvalid, 0);
        chk("R1", "if_stall", if_stall, 0);
        rst_n = 1'b1;
        // R2 start, R3 busy, R4 seq
        step(1, 32'h100, 1, 0, 1);
        step(1, 32'h104, 1, 0, 1);
        step(1, 32'h104, 1, 0, 1);
        step(1, 32'h108, 1, 0, 1);
        // R7 wait states in BUSY and data phase
        step(1, 32'h108, 1, 0, 0);
        step(1, 32'h108, 1, 0, 0);
        step(1, 32'h108, 1, 0, 1);
        // R5 branch
        step(1, 32'h200, 0, 0, 1);
        step(1, 32'h200, 0, 0, 1);
        step(1, 32'h204, 1, 0, 1);
        // R6 local fetch after BUSY
        step(1, 32'h204, 1, 1, 1);
        step(0, 32'h0, 0, 0, 1);
        // R11 boundary crossing
        step(1, 32'h3F8, 0, 0, 1);
        step(1, 32'h3FC, 1, 0, 1);
        step(1, 32'h3FC, 1, 0, 1);
        step(1, 32'h400, 1, 0, 1);
        step(1, 32'h400, 1, 0, 1);
        step(1, 32'h404, 1, 0, 1);
        step(0, 32'h0, 0, 0, 1);
        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned a;
            a = ($urandom_range(0, 3) == 0) ? (32'h400 * $urandom_range(1, 8) - 4 * $urandom_range(0, 2))
                                            : ($urandom & 32'hFFFF_FFFC);
            step($urandom_range(0, 7) != 0, a, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 3) != 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule